// File: doc/BRIEF.md
# BCD Real-Time Calendar with Initialisation Handshake

This block keeps the time of day and the calendar date as packed BCD fields. It runs entirely in the slow real-time clock domain. A two-stage prescaler divides that clock down to a once-per-second calendar tick. The first stage is a short free-running divider and the second a long one. Every field in the calendar advances on that tick: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week counter. Month lengths and leap years are applied when the day rolls over.

Software cannot change the calendar while it is counting. It first raises an initialisation request and waits for a ready flag, which appears a fixed number of clock edges later. While the block is in this mode, counting is frozen, and writes to the time word, the date word and the two prescaler limits are accepted. Dropping the request leaves the mode and restarts the prescaler from zero.

Reads are taken from a copy of the calendar. The copy follows the live counters only while a synchronised flag is set. Software may clear that flag. Leaving initialisation mode also clears it. Either way, hardware sets it again a fixed number of edges later, once the copy has been refreshed. A separate calendar-valid flag stays low after reset until the year field first holds a non-zero value.

Top module: `cal_bcd_rtc`

## Requirements
- R1: The time word packs BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. The date word packs BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year in bits 23:16. All other bits read 0. After reset and the first synchronisation, the date word reads 0x002101 and the time word reads 0x000000.
- R2: When the initialisation request is first sampled high at edge k and stays high, init_ready_o rises at edge k+INIT_LAT, not earlier. If the request drops before then, the block returns to counting and init_ready_o stays low.
- R3: Writes to the time word, the date word or the prescaler limits are ignored unless init_ready_o is high. Ignored writes leave the visible time unchanged and leave the tick rate unchanged.
- R4: Counting stops while the block is entering or in initialisation mode. The edge that leaves the mode resets both prescaler stages, so the first calendar advance lands exactly P edges after the exit edge.
- R5: With async limit A and sync limit S, the calendar advances once every P = (A+1)*(S+1) edges. The reset limits are A=127 and S=255.
- R6: Seconds and minutes count 00..59 and hours count 00..23 in BCD. Each field wraps to 00 and carries into the next field.
- R7: A sync-clear pulse at edge c, or the exit edge from initialisation mode, drives sync_flag_o low. sync_flag_o is set again at edge c+SYNC_LAT. While the flag is low, the time and date outputs hold. While it is high, they follow the live calendar one edge behind.
- R8: The day wraps to 01 after the last day of the month. That day is 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the binary year is divisible by 4 and 28 otherwise. For every other month it is 31. Month wraps 12 to 01 with a year carry, and year wraps 99 to 00.
- R9: The weekday uses 1 for Monday through 7 for Sunday. It advances by one on every day change and goes from 7 back to 1.
- R10: cal_valid_o is 0 after reset while the year is 00. It becomes 1 once the year is non-zero and stays 1 from then on, even if the year later wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Real-time clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_req_i | input | 1 | Initialisation mode request |
| init_ready_o | output | 1 | Block is in initialisation mode; writes are accepted |
| time_we_i | input | 1 | Time word write strobe |
| time_wdata_i | input | 22 | Time word to load (R1 layout) |
| date_we_i | input | 1 | Date word write strobe |
| date_wdata_i | input | 24 | Date word to load (R1 layout) |
| presc_we_i | input | 1 | Prescaler limits write strobe |
| presc_async_i | input | ASYNC_W | First-stage divider limit A |
| presc_sync_i | input | SYNC_W | Second-stage divider limit S |
| sync_clr_i | input | 1 | Clears the synchronised flag |
| sync_flag_o | output | 1 | Read copy is synchronised with the calendar |
| cal_valid_o | output | 1 | Calendar has been given a non-zero year |
| time_o | output | 22 | Read copy of the time word |
| date_o | output | 24 | Read copy of the date word |

## Verification
The bench goes after the month-end transitions for every month across several years, including leap years, year 00, and the 99-to-00 wrap with the weekday crossing Sunday. A wrong month-length table or leap test would land on a day 29, 31 or 32 where day 01 of the next month belongs. It sweeps a full day second by second to catch a BCD carry that is missed at 09, 59 or 23. It pins the exact edge of the first tick after initialisation exit. A design that forgot to reset the prescaler would tick early. The bench also times the ready and resynchronisation latencies, where an off-by-one shows up. Finally, it pulses writes outside initialisation mode, which a leaky write enable would let through as a jump in time or a changed tick rate.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned TIME_W = 22;
  localparam int unsigned DATE_W = 24;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [5:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_INIT  = 2'd2
  } cal_state_e;

  // Increment a two-digit BCD value (no wrap handling: caller wraps).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Binary value of a BCD year divisible by four: even tens with units
  // 0/4/8, or odd tens with units 2/6.
  function automatic logic leap_year(input logic [7:0] y);
    logic r;
    if (y[4] == 1'b0) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  // Last BCD day of a BCD month.
  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    logic [5:0] r;
    case (m)
      5'h02:                      r = leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned ASYNC_W   = 7,
  parameter int unsigned SYNC_W    = 15,
  parameter int unsigned ASYNC_RST = 127,
  parameter int unsigned SYNC_RST  = 255
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               ld_i,
  input  logic [ASYNC_W-1:0] a_lim_i,
  input  logic [SYNC_W-1:0]  s_lim_i,
  output logic               tick_o
);

  localparam logic [ASYNC_W-1:0] A_RST = ASYNC_W'(ASYNC_RST);
  localparam logic [SYNC_W-1:0]  S_RST = SYNC_W'(SYNC_RST);

  logic [ASYNC_W-1:0] a_lim_q, a_lim_d, a_q, a_d;
  logic [SYNC_W-1:0]  s_lim_q, s_lim_d, s_q, s_d;
  logic               a_wrap, s_wrap;

  assign a_wrap = (a_q == a_lim_q);
  assign s_wrap = (s_q == s_lim_q);
  assign tick_o = run_i && a_wrap && s_wrap;

  always_comb begin
    a_lim_d = a_lim_q;
    s_lim_d = s_lim_q;
    if (ld_i) begin
      a_lim_d = a_lim_i;
      s_lim_d = s_lim_i;
    end
  end

  always_comb begin
    a_d = a_q;
    s_d = s_q;
    if (!run_i) begin
      a_d = '0;
      s_d = '0;
    end else if (a_wrap) begin
      a_d = '0;
      s_d = s_wrap ? '0 : s_q + 1'b1;
    end else begin
      a_d = a_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_lim_q <= A_RST;
      s_lim_q <= S_RST;
      a_q     <= '0;
      s_q     <= '0;
    end else begin
      a_lim_q <= a_lim_d;
      s_lim_q <= s_lim_d;
      a_q     <= a_d;
      s_q     <= s_d;
    end
  end

  assert_async_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_q <= a_lim_q);
  assert_sync_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q <= s_lim_q);
  assert_halt_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (a_q == '0) && (s_q == '0));

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_time_i,
  input  logic              wr_date_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [DATE_W-1:0] date_i,
  output cal_t              cal_o
);

  cal_t       cal_q, cal_d;
  logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
  logic [7:0] sec_inc, min_inc, hour_inc, day_inc, mon_inc, year_inc;

  assign sec_wrap  = (cal_q.sec  == 7'h59);
  assign min_wrap  = (cal_q.min  == 7'h59);
  assign hour_wrap = (cal_q.hour == 6'h23);
  assign day_wrap  = (cal_q.day  == last_day(cal_q.mon, cal_q.year));
  assign mon_wrap  = (cal_q.mon  == 5'h12);

  assign sec_inc  = bcd_inc({1'b0, cal_q.sec});
  assign min_inc  = bcd_inc({1'b0, cal_q.min});
  assign hour_inc = bcd_inc({2'b0, cal_q.hour});
  assign day_inc  = bcd_inc({2'b0, cal_q.day});
  assign mon_inc  = bcd_inc({3'b0, cal_q.mon});
  assign year_inc = (cal_q.year == 8'h99) ? 8'h00 : bcd_inc(cal_q.year);

  always_comb begin
    cal_d = cal_q;
    if (tick_i) begin
      cal_d.sec = sec_wrap ? 7'h00 : sec_inc[6:0];
      if (sec_wrap) begin
        cal_d.min = min_wrap ? 7'h00 : min_inc[6:0];
        if (min_wrap) begin
          cal_d.hour = hour_wrap ? 6'h00 : hour_inc[5:0];
          if (hour_wrap) begin
            cal_d.wday = (cal_q.wday == 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
            cal_d.day  = day_wrap ? 6'h01 : day_inc[5:0];
            if (day_wrap) begin
              cal_d.mon = mon_wrap ? 5'h01 : mon_inc[4:0];
              if (mon_wrap) cal_d.year = year_inc;
            end
          end
        end
      end
    end else begin
      if (wr_time_i) begin
        cal_d.sec  = time_i[6:0];
        cal_d.min  = time_i[14:8];
        cal_d.hour = time_i[21:16];
      end
      if (wr_date_i) begin
        cal_d.day  = date_i[5:0];
        cal_d.mon  = date_i[12:8];
        cal_d.wday = date_i[15:13];
        cal_d.year = date_i[23:16];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= '{year: 8'h00, wday: 3'd1, mon: 5'h01, day: 6'h01,
                 hour: 6'h00, min: 7'h00, sec: 7'h00};
    end else begin
      cal_q <= cal_d;
    end
  end

  assign cal_o = cal_q;

  assert_sec_bcd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q.sec[3:0] <= 4'd9) && (cal_q.sec <= 7'h59));
  assert_hour_bcd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q.hour[3:0] <= 4'd9) && (cal_q.hour <= 6'h23));
  assert_day_in_month_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q.day != 6'h00) && (cal_q.day <= last_day(cal_q.mon, cal_q.year)));
  assert_wday_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q.wday != 3'd0));

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int unsigned INIT_LAT = 2,
  parameter int unsigned SYNC_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_req_i,
  input  logic sync_clr_i,
  input  cal_t cal_i,
  output logic init_ready_o,
  output logic run_o,
  output logic wr_ok_o,
  output logic sync_flag_o,
  output logic cal_valid_o,
  output cal_t shadow_o
);

  localparam int unsigned IW = $clog2(INIT_LAT + 1);
  localparam int unsigned SW = $clog2(SYNC_LAT + 1);
  localparam logic [IW-1:0] I_LOAD = IW'(INIT_LAT - 1);
  localparam logic [SW-1:0] S_LOAD = SW'(SYNC_LAT - 1);

  cal_state_e    st_q, st_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          flag_q, flag_d, pend_q, pend_d, valid_q, valid_d;
  logic          leave, restart, done, shadow_en;
  cal_t          shadow_q, shadow_d;

  assign leave   = (st_q == ST_INIT) && !init_req_i;
  assign restart = leave || sync_clr_i;
  assign done    = !restart && pend_q && (scnt_q == '0);

  // Mode state machine
  always_comb begin
    st_d   = st_q;
    icnt_d = icnt_q;
    case (st_q)
      ST_RUN: if (init_req_i) begin
        st_d   = ST_ENTER;
        icnt_d = I_LOAD;
      end
      ST_ENTER: begin
        if (!init_req_i)         st_d = ST_RUN;
        else if (icnt_q == '0)   st_d = ST_INIT;
        else                     icnt_d = icnt_q - 1'b1;
      end
      ST_INIT: if (!init_req_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  // Synchronisation flag
  always_comb begin
    flag_d = flag_q;
    pend_d = pend_q;
    scnt_d = scnt_q;
    if (restart) begin
      flag_d = 1'b0;
      pend_d = 1'b1;
      scnt_d = S_LOAD;
    end else if (pend_q) begin
      if (scnt_q == '0) begin
        flag_d = 1'b1;
        pend_d = 1'b0;
      end else begin
        scnt_d = scnt_q - 1'b1;
      end
    end
  end

  assign shadow_en = done || flag_q;
  always_comb begin
    shadow_d = shadow_q;
    if (shadow_en) shadow_d = cal_i;
  end

  assign valid_d = valid_q || (cal_i.year != 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      icnt_q   <= '0;
      flag_q   <= 1'b0;
      pend_q   <= 1'b1;
      scnt_q   <= S_LOAD;
      valid_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      st_q     <= st_d;
      icnt_q   <= icnt_d;
      flag_q   <= flag_d;
      pend_q   <= pend_d;
      scnt_q   <= scnt_d;
      valid_q  <= valid_d;
      shadow_q <= shadow_d;
    end
  end

  assign init_ready_o = (st_q == ST_INIT);
  assign wr_ok_o      = (st_q == ST_INIT);
  assign run_o        = (st_q == ST_RUN);
  assign sync_flag_o  = flag_q;
  assign cal_valid_o  = valid_q;
  assign shadow_o     = shadow_q;

  assert_ready_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_ready_o) |-> $past(init_req_i));
  assert_sync_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> !sync_flag_o);
  assert_exit_resync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_ready_o && !init_req_i) |=> !sync_flag_o && run_o);
  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_flag_o && !done) |=> $stable(shadow_o));
  assert_valid_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_valid_o |=> cal_valid_o);

endmodule

// File: rtl/cal_bcd_rtc.sv
module cal_bcd_rtc
  import cal_pkg::*;
#(
  parameter int unsigned ASYNC_W    = 7,
  parameter int unsigned SYNC_W     = 15,
  parameter int unsigned ASYNC_RST  = 127,
  parameter int unsigned SYNC_RST   = 255,
  parameter int unsigned INIT_LAT   = 2,
  parameter int unsigned SYNC_LAT   = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_req_i,
  output logic               init_ready_o,
  input  logic               time_we_i,
  input  logic [21:0]        time_wdata_i,
  input  logic               date_we_i,
  input  logic [23:0]        date_wdata_i,
  input  logic               presc_we_i,
  input  logic [ASYNC_W-1:0] presc_async_i,
  input  logic [SYNC_W-1:0]  presc_sync_i,
  input  logic               sync_clr_i,
  output logic               sync_flag_o,
  output logic               cal_valid_o,
  output logic [21:0]        time_o,
  output logic [23:0]        date_o
);

  logic rst_n, run, wr_ok, tick;
  cal_t live, shadow;

  cal_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  cal_ctrl #(.INIT_LAT(INIT_LAT), .SYNC_LAT(SYNC_LAT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .init_req_i  (init_req_i),
    .sync_clr_i  (sync_clr_i),
    .cal_i       (live),
    .init_ready_o(init_ready_o),
    .run_o       (run),
    .wr_ok_o     (wr_ok),
    .sync_flag_o (sync_flag_o),
    .cal_valid_o (cal_valid_o),
    .shadow_o    (shadow)
  );

  cal_prescaler #(
    .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W),
    .ASYNC_RST(ASYNC_RST), .SYNC_RST(SYNC_RST)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .ld_i   (presc_we_i && wr_ok),
    .a_lim_i(presc_async_i),
    .s_lim_i(presc_sync_i),
    .tick_o (tick)
  );

  cal_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_time_i(time_we_i && wr_ok),
    .wr_date_i(date_we_i && wr_ok),
    .time_i   (time_wdata_i),
    .date_i   (date_wdata_i),
    .cal_o    (live)
  );

  assign time_o = {shadow.hour, 1'b0, shadow.min, 1'b0, shadow.sec};
  assign date_o = {shadow.year, shadow.wday, shadow.mon, 2'b00, shadow.day};

  assert_no_tick_in_init_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    init_ready_o |-> !tick);

endmodule

// File: tb/test_cal_bcd_rtc.sv
module test_cal_bcd_rtc;

  localparam int INIT_LAT = 2;
  localparam int SYNC_LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0, time_we = 1'b0, date_we = 1'b0, presc_we = 1'b0, sync_clr = 1'b0;
  logic [21:0] time_wd = '0;
  logic [23:0] date_wd = '0;
  logic [6:0]  pa = '0;
  logic [14:0] ps = '0;
  logic        ready, sflag, cvalid;
  logic [21:0] time_q;
  logic [23:0] date_q;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_bcd_rtc #(.INIT_LAT(INIT_LAT), .SYNC_LAT(SYNC_LAT)) i_cal_bcd_rtc (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .init_ready_o(ready),
    .time_we_i(time_we), .time_wdata_i(time_wd), .date_we_i(date_we),
    .date_wdata_i(date_wd), .presc_we_i(presc_we), .presc_async_i(pa),
    .presc_sync_i(ps), .sync_clr_i(sync_clr), .sync_flag_o(sflag),
    .cal_valid_o(cvalid), .time_o(time_q), .date_o(date_q));

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int tword(int h, int m, int s);
    return (bcd(h) << 16) | (bcd(m) << 8) | bcd(s);
  endfunction
  function automatic int dword(int y, int w, int mo, int d);
    return (bcd(y) << 16) | (w << 13) | (bcd(mo) << 8) | bcd(d);
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic enter_init();
    init_req = 1'b1;
    for (int i = 0; i < 40 && !ready; i++) @(negedge clk);
  endtask

  task automatic put_time(int v);
    time_we = 1'b1; time_wd = 22'(v);
    @(negedge clk); time_we = 1'b0;
  endtask
  task automatic put_date(int v);
    date_we = 1'b1; date_wd = 24'(v);
    @(negedge clk); date_we = 1'b0;
  endtask
  task automatic put_presc(int a, int s);
    presc_we = 1'b1; pa = 7'(a); ps = 15'(s);
    @(negedge clk); presc_we = 1'b0;
  endtask

  // Drops the request; returns just after the exit edge e.
  task automatic leave_init();
    init_req = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    // Reset state (R1, R10)
    repeat (3) @(negedge clk);
    check("R1 time in reset", int'(time_q), 0);
    check("R7 flag in reset", int'(sflag), 0);
    check("R10 valid in reset", int'(cvalid), 0);
    check("R2 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 flag after reset sync", int'(sflag), 1);
    check("R1 date after reset", int'(date_q), 32'h002101);
    check("R1 time after reset", int'(time_q), 0);
    check("R10 valid year 00", int'(cvalid), 0);

    // R2: ready latency
    init_req = 1'b1;
    @(posedge clk);
    for (int i = 0; i < INIT_LAT; i++) begin
      @(negedge clk);
      check("R2 ready early", int'(ready), (i == INIT_LAT - 1) ? 0 : 0);
      if (i < INIT_LAT - 1) ;
    end
    @(negedge clk);
    check("R2 ready at latency", int'(ready), 1);
    init_req = 1'b0;
    @(negedge clk);
    check("R2 ready drops", int'(ready), 0);
    // Aborted request
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    repeat (INIT_LAT + 3) @(negedge clk);
    check("R2 aborted request", int'(ready), 0);

    // R3: writes outside init mode
    t0 = int'(time_q);
    put_time(tword(12, 34, 56));
    put_date(dword(45, 3, 6, 7));
    put_presc(0, 0);
    repeat (20) @(negedge clk);
    check("R3 time write ignored", int'(time_q), t0);
    check("R3 date write ignored", int'(date_q), 32'h002101);
    // Write issued on the request edge, before ready
    init_req = 1'b1;
    put_time(tword(7, 7, 7));
    enter_init();
    repeat (4) @(negedge clk);
    check("R3 write while entering", int'(time_q), t0);

    // R4, R5, R7: exact tick phase with P = 6
    put_presc(1, 2);
    put_time(tword(1, 2, 3));
    leave_init();
    for (int n = 0; n <= 20; n++) begin
      @(negedge clk);
      if (n < SYNC_LAT) check("R7 flag low after exit", int'(sflag), 0);
      else begin
        check("R7 flag set after exit", int'(sflag), 1);
        check("R4 R5 tick phase", int'(time_q), tword(1, 2, 3 + (n - 1) / 6));
      end
    end

    // R7: software clear
    sync_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sync_clr = 1'b0;
    t0 = int'(time_q);
    check("R7 flag cleared", int'(sflag), 0);
    for (int n = 1; n < SYNC_LAT; n++) begin
      @(negedge clk);
      check("R7 flag still low", int'(sflag), 0);
      check("R7 copy frozen", int'(time_q), t0);
    end
    @(negedge clk);
    check("R7 flag re-set", int'(sflag), 1);

    // R6, R9, R10: full-day sweep at P = 1
    enter_init();
    put_presc(0, 0);
    put_time(tword(0, 0, 0));
    put_date(dword(24, 5, 3, 15));
    leave_init();
    for (int n = 0; n <= 86402; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        int el;
        el = (n - 1) % 86400;
        check("R6 second sweep", int'(time_q), tword(el / 3600, (el / 60) % 60, el % 60));
      end
    end
    check("R9 weekday next day", int'(date_q), dword(24, 6, 3, 16));
    check("R10 valid after year set", int'(cvalid), 1);

    // R8, R9: month ends over several years
    begin
      int years[5] = '{0, 1, 4, 98, 99};
      int w = 1;
      foreach (years[yi]) begin
        for (int mo = 1; mo <= 12; mo++) begin
          int y, d, ny, nm, nd, nw;
          y  = years[yi];
          d  = mlen(mo, y);
          nd = 1;
          nm = (mo == 12) ? 1 : mo + 1;
          ny = (mo == 12) ? (y + 1) % 100 : y;
          nw = (w == 7) ? 1 : w + 1;
          enter_init();
          put_time(tword(23, 59, 59));
          put_date(dword(y, w, mo, d));
          leave_init();
          repeat (SYNC_LAT + 1) @(negedge clk);
          check("R8 R9 month end date", int'(date_q), dword(ny, nw, nm, nd));
          check("R6 midnight time", int'(time_q), tword(0, 0, 0));
          w = nw;
        end
      end
    end
    check("R10 valid after year wrap", int'(cvalid), 1);

    // R8: Feb 28 in leap and common year
    enter_init();
    put_time(tword(23, 59, 59));
    put_date(dword(8, 7, 2, 28));
    leave_init();
    repeat (SYNC_LAT + 1) @(negedge clk);
    check("R8 R9 leap Feb 28", int'(date_q), dword(8, 1, 2, 29));
    enter_init();
    put_time(tword(23, 59, 59));
    put_date(dword(10, 2, 2, 28));
    leave_init();
    repeat (SYNC_LAT + 1) @(negedge clk);
    check("R8 common Feb 28", int'(date_q), dword(10, 3, 3, 1));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule